// File: doc/BRIEF.md
# Programmable Interrupt Controller

An eight-line interrupt controller driven from a byte-wide bus with two addresses: a command address and a data address. Software programs it with a start command followed by three data bytes (vector base, cascade byte, mode byte), then steers it with operation commands: end-of-interrupt in several forms, priority rotation, special mask mode, poll and the choice of which status register the command address reads back. Each request line is captured either on a rising edge or as a level, chosen per line by the `trig_lvl` input.

Once programmed, the controller raises `int_req` whenever an unmasked pending line beats every in-service line in the current rotating order, and shows `int_vec` as the base byte ORed with the winning level. A pulse on `int_ack` moves the winner from the pending register into the in-service register. Software without an acknowledge cycle can poll instead: a read of the command address after a poll command returns the winner and acknowledges it.

Top module: `irq_ctl`

## Requirements
- R1: A command write with bit 4 set clears pending, in-service and mask registers and every mode flag, and makes level 7 the lowest priority; the following three data writes are taken as vector base, cascade byte (ignored) and mode byte.
- R2: `int_req` stays low until the mode byte has been written; afterwards `int_req` is high exactly when a grant exists and `int_vec` equals base OR the granted level.
- R3: The priority search begins at lowest-priority level + 1 and wraps modulo 8; the first line set in (pending AND NOT mask) OR (blocking in-service) wins, and a win by an in-service line means no grant.
- R4: A line with its `trig_lvl` bit 0 sets its pending bit on a rising input; a line with its `trig_lvl` bit 1 has its pending bit copy the input every cycle.
- R5: An `int_ack` pulse clears the granted pending bit (edge lines) and sets its in-service bit, which then blocks that level and all levels after it in the order.
- R6: Mode byte bit 1 selects automatic end-of-interrupt: an acknowledge leaves the in-service bit clear, and when the rotate flag is set (command 0x80, cleared by 0x00) the acknowledged level becomes the lowest priority.
- R7: Command 0x20 clears the in-service bit that comes first in the current order; command 0xA0 does the same and makes that level the lowest priority.
- R8: Command 0x60|L clears in-service bit L; 0xC0|L makes L the lowest priority; 0xE0|L does both.
- R9: Command 0x0B makes command-address reads return the in-service register and 0x0A makes them return the pending register (the reset choice).
- R10: Command 0x68 enters and 0x48 leaves special mask mode; in that mode with a non-zero mask, in-service bits block nothing.
- R11: After command 0x0C the next command-address read returns 0x80|level and acknowledges that level, or 0x00 with nothing granted; later reads return the selected status register again.
- R12: Data-address reads return the mask; a data write after initialization sets the mask (bit 1 masks a line) and `int_req` reflects it from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe, one cycle per byte |
| bus_sel | input | 1 | 0 selects the command address, 1 the data address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected address |
| irq_lines | input | 8 | Request lines |
| trig_lvl | input | 8 | Per-line trigger: 1 level, 0 rising edge |
| int_ack | input | 1 | Acknowledge pulse |
| int_req | output | 1 | Interrupt request |
| int_vec | output | 8 | Vector: base OR granted level |

## Verification
The assertions assume a bus master that never writes and reads in the same cycle and never issues an end-of-interrupt or initialization command in the cycle an acknowledge or poll read lands; the bench keeps every strobe in its own cycle to stay inside that. They also assume the request lines and trigger select change only between clock edges, which the bench guarantees by driving them on the falling edge. A behavioural model in the bench tracks every register and compares request, vector and read data after each edge.

// File: rtl/pic_pkg.sv
package pic_pkg;
  parameter int PIC_LINES = 8;
  localparam int PIC_LW = $clog2(PIC_LINES);

  typedef logic [PIC_LINES-1:0] line_t;
  typedef logic [PIC_LW-1:0]    lvl_t;

  typedef enum logic [2:0] {S_IDLE, S_BASE, S_CASC, S_MODE, S_RUN} init_e;

  // First set bit of v when scanning from low+1 upward, wrapping.
  function automatic line_t rot_pick(line_t v, lvl_t low);
    line_t r;
    logic  hit;
    int    idx;
    r   = '0;
    hit = 1'b0;
    for (int k = 1; k <= PIC_LINES; k++) begin
      idx = (int'(low) + k) % PIC_LINES;
      if (!hit && v[idx]) begin
        r[idx] = 1'b1;
        hit    = 1'b1;
      end
    end
    return r;
  endfunction

  function automatic lvl_t oh_to_lvl(line_t oh);
    lvl_t l;
    l = '0;
    for (int k = 0; k < PIC_LINES; k++)
      if (oh[k]) l = l | lvl_t'(k);
    return l;
  endfunction
endpackage

// File: rtl/pic_irr.sv
module pic_irr
  import pic_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  line_t lines,
  input  line_t trig_lvl,
  input  logic  clr_all,
  input  line_t ack_clr,
  output line_t irr
);
  line_t prev_q;
  line_t rise;

  assign rise = lines & ~prev_q;

  for (genvar i = 0; i < PIC_LINES; i++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q[i] <= 1'b0;
        irr[i]    <= 1'b0;
      end else begin
        prev_q[i] <= lines[i];
        if (clr_all)          irr[i] <= 1'b0;
        else if (trig_lvl[i]) irr[i] <= lines[i];
        else if (rise[i])     irr[i] <= 1'b1;
        else if (ack_clr[i])  irr[i] <= 1'b0;
      end
    end

    AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (rise[i] && !trig_lvl[i] && !clr_all) |=> irr[i]); // R4
    AST_LEVEL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_lvl[i] && !clr_all) |=> (irr[i] == $past(lines[i]))); // R4
  end
endmodule

// File: rtl/pic_resolve.sv
module pic_resolve
  import pic_pkg::*;
(
  input  line_t irr,
  input  line_t imr,
  input  line_t isr,
  input  logic  smm,
  input  lvl_t  low,
  output line_t grant,
  output lvl_t  grant_lvl,
  output logic  grant_any,
  output line_t isr_top,
  output lvl_t  isr_top_lvl
);
  line_t block;
  line_t cand;

  always_comb begin
    block       = (smm && (imr != '0)) ? '0 : isr;
    cand        = rot_pick((irr & ~imr) | block, low);
    grant       = cand & ~block;
    grant_any   = (grant != '0);
    grant_lvl   = oh_to_lvl(grant);
    isr_top     = rot_pick(isr, low);
    isr_top_lvl = oh_to_lvl(isr_top);
  end
endmodule

// File: rtl/irq_ctl.sv
module irq_ctl
  import pic_pkg::*;
#(
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic             bus_sel,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  input  logic [PIC_LINES-1:0] irq_lines,
  input  logic [PIC_LINES-1:0] trig_lvl,
  input  logic             int_ack,
  output logic             int_req,
  output logic [BUS_W-1:0] int_vec
);
  localparam int PAD_W = BUS_W - 1 - PIC_LW;
  localparam lvl_t LOW_RESET = lvl_t'(PIC_LINES - 1);

  init_e st_q;
  line_t irr, isr_q, imr_q;
  lvl_t  low_q;
  logic [BUS_W-1:0] base_q;
  logic  aeoi_q, rot_q, smm_q, poll_q, rsr_q;

  line_t grant, isr_top;
  lvl_t  grant_lvl, isr_top_lvl;
  logic  grant_any;

  // Named bus events
  logic cmd_wr, dat_wr, icw1, ocw2, ocw3, poll_take, ack_evt;
  logic [2:0] op;
  lvl_t  op_lvl;
  line_t op_oh, isr_set, isr_clr;

  assign cmd_wr    = bus_wr & ~bus_sel;
  assign dat_wr    = bus_wr & bus_sel;
  assign icw1      = cmd_wr & bus_wdata[4];
  assign ocw2      = cmd_wr & ~bus_wdata[4] & ~bus_wdata[3];
  assign ocw3      = cmd_wr & ~bus_wdata[7] & ~bus_wdata[4] & bus_wdata[3];
  assign op        = bus_wdata[7:5];
  assign op_lvl    = lvl_t'(bus_wdata[PIC_LW-1:0]);
  assign op_oh     = line_t'(1) << op_lvl;
  assign poll_take = bus_rd & ~bus_sel & poll_q;
  assign ack_evt   = (int_ack | poll_take) & grant_any;

  pic_irr u_irr (
    .clk      (clk),
    .rst_n    (rst_n),
    .lines    (irq_lines),
    .trig_lvl (trig_lvl),
    .clr_all  (icw1),
    .ack_clr  (ack_evt ? grant : '0),
    .irr      (irr)
  );

  pic_resolve u_res (
    .irr         (irr),
    .imr         (imr_q),
    .isr         (isr_q),
    .smm         (smm_q),
    .low         (low_q),
    .grant       (grant),
    .grant_lvl   (grant_lvl),
    .grant_any   (grant_any),
    .isr_top     (isr_top),
    .isr_top_lvl (isr_top_lvl)
  );

  always_comb begin
    isr_set = (ack_evt && !aeoi_q) ? grant : '0;
    isr_clr = '0;
    if (ocw2) begin
      case (op)
        3'd1, 3'd5: isr_clr = isr_top;
        3'd3, 3'd7: isr_clr = op_oh;
        default:    isr_clr = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      isr_q  <= '0;
      imr_q  <= '0;
      low_q  <= LOW_RESET;
      base_q <= '0;
      aeoi_q <= 1'b0;
      rot_q  <= 1'b0;
      smm_q  <= 1'b0;
      poll_q <= 1'b0;
      rsr_q  <= 1'b0;
    end else if (icw1) begin
      st_q   <= S_BASE;
      isr_q  <= '0;
      imr_q  <= '0;
      low_q  <= LOW_RESET;
      aeoi_q <= 1'b0;
      rot_q  <= 1'b0;
      smm_q  <= 1'b0;
      poll_q <= 1'b0;
      rsr_q  <= 1'b0;
    end else begin
      isr_q <= (isr_q | isr_set) & ~isr_clr;
      if (poll_take) poll_q <= 1'b0;
      if (ack_evt && aeoi_q && rot_q) low_q <= grant_lvl;
      if (dat_wr) begin
        case (st_q)
          S_BASE: begin base_q <= bus_wdata; st_q <= S_CASC; end
          S_CASC: st_q <= S_MODE;
          S_MODE: begin aeoi_q <= bus_wdata[1]; st_q <= S_RUN; end
          default: imr_q <= line_t'(bus_wdata);
        endcase
      end
      if (ocw2) begin
        case (op)
          3'd0: rot_q <= 1'b0;
          3'd4: rot_q <= 1'b1;
          3'd5: if (isr_q != '0) low_q <= isr_top_lvl;
          3'd6, 3'd7: low_q <= op_lvl;
          default: ;
        endcase
      end
      if (ocw3) begin
        if (bus_wdata[6]) smm_q  <= bus_wdata[5];
        if (bus_wdata[2]) poll_q <= 1'b1;
        if (bus_wdata[1]) rsr_q  <= bus_wdata[0];
      end
    end
  end

  always_comb begin
    if (bus_sel)     bus_rdata = BUS_W'(imr_q);
    else if (poll_q) bus_rdata = grant_any ? {1'b1, {PAD_W{1'b0}}, grant_lvl} : '0;
    else if (rsr_q)  bus_rdata = BUS_W'(isr_q);
    else             bus_rdata = BUS_W'(irr);
  end

  assign int_req = (st_q == S_RUN) & grant_any;
  assign int_vec = base_q | BUS_W'(grant_lvl);

  AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    icw1 |=> (isr_q == '0 && imr_q == '0 && low_q == LOW_RESET)); // R1
  AST_NO_EARLY_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != S_RUN) |-> !int_req); // R2
  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R3
  AST_ACK_TO_ISR: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_evt && !aeoi_q && !cmd_wr) |=> ((isr_q & $past(grant)) != '0)); // R5
  AST_AEOI_NO_ISR: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_evt && aeoi_q && !cmd_wr) |=> ((isr_q & $past(grant)) == '0)); // R6
  AST_EOI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ocw2 && op == 3'd1 && !ack_evt) |=> ((isr_q & $past(isr_top)) == '0)); // R7
  AST_POLL_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_take && !ocw3) |=> !poll_q); // R11
  AST_GRANT_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant & imr_q) == '0)); // R12
endmodule

// File: tb/irq_ctl_tb.sv
module irq_ctl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0, bus_sel = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [7:0] irq_lines = 8'h00;
  logic [7:0] trig_lvl = 8'h00;
  logic int_ack = 1'b0;
  logic int_req;
  logic [7:0] int_vec;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_lines(irq_lines), .trig_lvl(trig_lvl), .int_ack(int_ack),
    .int_req(int_req), .int_vec(int_vec)
  );

  // ---------------- behavioural reference model ----------------
  logic [7:0] m_irr, m_isr, m_imr, m_base, m_prev;
  int m_low, m_st;
  bit m_aeoi, m_rot, m_smm, m_poll, m_rsr;

  function automatic int first_in(logic [7:0] v, int low);
    for (int k = 1; k <= 8; k++) begin
      int idx;
      idx = (low + k) % 8;
      if (v[idx]) return idx;
    end
    return -1;
  endfunction

  function automatic int m_grant();
    logic [7:0] blk;
    int f;
    blk = (m_smm && m_imr != 8'h00) ? 8'h00 : m_isr;
    f = first_in((m_irr & ~m_imr) | blk, m_low);
    if (f >= 0 && blk[f]) f = -1;
    return f;
  endfunction

  task automatic model_reset();
    m_irr = 0; m_isr = 0; m_imr = 0; m_base = 0; m_prev = 0;
    m_low = 7; m_st = 0;
    m_aeoi = 0; m_rot = 0; m_smm = 0; m_poll = 0; m_rsr = 0;
  endtask

  task automatic model_step();
    int g, top;
    bit ack, ptake;
    logic [7:0] old_isr;
    logic [7:0] d;
    g = m_grant();
    old_isr = m_isr;
    top = first_in(old_isr, m_low);
    ptake = bus_rd && !bus_sel && m_poll;
    ack = (int_ack || ptake) && (g >= 0);
    d = bus_wdata;
    for (int i = 0; i < 8; i++) begin
      if (trig_lvl[i]) m_irr[i] = irq_lines[i];
      else m_irr[i] = (m_irr[i] && !(ack && g == i)) || (irq_lines[i] && !m_prev[i]);
    end
    m_prev = irq_lines;
    if (ack) begin
      if (!m_aeoi) m_isr[g] = 1'b1;
      else if (m_rot) m_low = g;
    end
    if (ptake) m_poll = 0;
    if (bus_wr && bus_sel) begin
      case (m_st)
        1: begin m_base = d; m_st = 2; end
        2: m_st = 3;
        3: begin m_aeoi = d[1]; m_st = 4; end
        default: m_imr = d;
      endcase
    end
    if (bus_wr && !bus_sel && !d[4] && !d[3]) begin
      case (d[7:5])
        0: m_rot = 0;
        1: if (top >= 0) m_isr[top] = 0;
        3: m_isr[d[2:0]] = 0;
        4: m_rot = 1;
        5: if (top >= 0) begin m_isr[top] = 0; m_low = top; end
        6: m_low = d[2:0];
        7: begin m_isr[d[2:0]] = 0; m_low = d[2:0]; end
        default: ;
      endcase
    end
    if (bus_wr && !bus_sel && !d[7] && !d[4] && d[3]) begin
      if (d[6]) m_smm = d[5];
      if (d[2]) m_poll = 1;
      if (d[1]) m_rsr = d[0];
    end
    if (bus_wr && !bus_sel && d[4]) begin
      m_irr = 0; m_isr = 0; m_imr = 0; m_low = 7; m_st = 1;
      m_aeoi = 0; m_rot = 0; m_smm = 0; m_poll = 0; m_rsr = 0;
    end
  endtask

  always @(posedge clk) begin
    int g;
    bit ereq;
    logic [7:0] erd;
    if (!rst_n) model_reset();
    else model_step();
    #2;
    if (rst_n && !done) begin
      g = m_grant();
      ereq = (m_st == 4) && (g >= 0);
      if (bus_sel) erd = m_imr;
      else if (m_poll) erd = (g >= 0) ? (8'h80 | 8'(g)) : 8'h00;
      else if (m_rsr) erd = m_isr;
      else erd = m_irr;
      checks++;
      if (int_req !== ereq || (ereq && int_vec !== (m_base | 8'(g))) || bus_rdata !== erd) begin
        errors++;
        $display("FAIL model R2 R3 R9: req=%0b vec=%h rd=%h expected req=%0b vec=%h rd=%h",
                 int_req, int_vec, bus_rdata, ereq, m_base | 8'(g), erd);
      end
    end
  end

  // ---------------- directed stimulus ----------------
  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic sel, logic [7:0] d);
    @(negedge clk); bus_wr = 1; bus_sel = sel; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd_chk(logic sel, logic [7:0] exp, string tag);
    @(negedge clk); bus_rd = 1; bus_sel = sel;
    #2 chk(tag, bus_rdata, exp);
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic pulse(logic [7:0] m);
    @(negedge clk); irq_lines = irq_lines | m;
    @(negedge clk); irq_lines = irq_lines & ~m;
  endtask

  task automatic ack();
    @(negedge clk); int_ack = 1;
    @(negedge clk); int_ack = 0;
  endtask

  task automatic req_chk(logic exp_req, logic [7:0] exp_vec, string tag);
    @(negedge clk);
    chk(tag, {7'd0, int_req}, {7'd0, exp_req});
    if (exp_req) chk(tag, int_vec, exp_vec);
  endtask

  initial begin
    #(200000 * 8);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    req_chk(0, 8'h00, "R2 reset no request");
    rd_chk(1, 8'h00, "R1 reset mask");
    rd_chk(0, 8'h00, "R1 reset IRR");
    // line 3 goes high before programming
    @(negedge clk); irq_lines = 8'h08;
    req_chk(0, 8'h00, "R2 no request before init");
    // normal init, base 0x40, no AEOI
    wr(0, 8'h11); wr(1, 8'h40); wr(1, 8'h04); wr(1, 8'h01);
    req_chk(0, 8'h00, "R1 init cleared IRR");
    @(negedge clk); irq_lines = 8'h00;
    // fixed order: 2 beats 5
    pulse(8'h24);
    req_chk(1, 8'h42, "R3 level 2 first");
    rd_chk(0, 8'h24, "R9 IRR default read");
    ack();
    req_chk(0, 8'h00, "R5 ISR 2 blocks level 5");
    wr(0, 8'h0B);
    rd_chk(0, 8'h04, "R9 ISR read");
    wr(0, 8'h20);
    req_chk(1, 8'h45, "R7 EOI releases level 5");
    ack();
    rd_chk(0, 8'h20, "R5 ISR after ack 5");
    pulse(8'h02);
    req_chk(1, 8'h41, "R5 higher level nests");
    ack();
    rd_chk(0, 8'h22, "R5 nested ISR");
    wr(0, 8'h20);
    rd_chk(0, 8'h20, "R7 non-specific clears top");
    wr(0, 8'h65);
    rd_chk(0, 8'h00, "R8 specific EOI");
    // set priority: lowest 3
    wr(0, 8'hC3);
    pulse(8'h44);
    req_chk(1, 8'h46, "R8 set priority order");
    ack();
    req_chk(0, 8'h00, "R3 in-service 6 blocks 2");
    wr(0, 8'hE6);
    req_chk(1, 8'h42, "R8 rotate specific");
    ack();
    wr(0, 8'h20);
    rd_chk(0, 8'h00, "R7 ISR empty");
    // mask
    wr(1, 8'hFF);
    pulse(8'h01);
    req_chk(0, 8'h00, "R12 masked line");
    rd_chk(1, 8'hFF, "R12 mask readback");
    wr(1, 8'hFE);
    req_chk(1, 8'h40, "R12 unmask next cycle");
    ack();
    wr(0, 8'h20);
    // special mask mode
    wr(1, 8'h01);
    pulse(8'h08);
    ack();
    pulse(8'h20);
    req_chk(0, 8'h00, "R10 normal mode blocks");
    wr(0, 8'h68);
    req_chk(1, 8'h45, "R10 special mask lets 5 in");
    wr(0, 8'h48);
    req_chk(0, 8'h00, "R10 left special mask");
    wr(0, 8'h63);
    req_chk(1, 8'h45, "R8 specific EOI level 3");
    ack();
    wr(0, 8'h65);
    wr(1, 8'h00);
    // poll
    pulse(8'h80);
    wr(0, 8'h0C);
    rd_chk(0, 8'h87, "R11 poll read");
    rd_chk(0, 8'h80, "R11 poll flag cleared");
    wr(0, 8'h67);
    wr(0, 8'h0C);
    rd_chk(0, 8'h00, "R11 poll empty");
    // level trigger on line 4
    @(negedge clk); trig_lvl = 8'h10;
    @(negedge clk); irq_lines = 8'h10;
    req_chk(1, 8'h44, "R4 level request");
    wr(0, 8'h0A);
    rd_chk(0, 8'h10, "R4 IRR follows level");
    @(negedge clk); irq_lines = 8'h00;
    req_chk(0, 8'h00, "R4 level drop");
    @(negedge clk); trig_lvl = 8'h00;
    // re-init with automatic EOI, base 0x80
    wr(0, 8'h11); wr(1, 8'h80);
    pulse(8'h40);
    req_chk(0, 8'h00, "R2 mid-sequence no request");
    wr(1, 8'h04); wr(1, 8'h03);
    req_chk(1, 8'h86, "R2 request after mode byte");
    rd_chk(1, 8'h00, "R1 mask cleared by init");
    ack();
    wr(0, 8'h0B);
    rd_chk(0, 8'h00, "R6 AEOI leaves ISR clear");
    wr(0, 8'h80);
    pulse(8'h08);
    ack();
    pulse(8'h14);
    req_chk(1, 8'h84, "R6 rotate on AEOI");
    ack();
    req_chk(1, 8'h82, "R6 rotated next");
    ack();
    wr(0, 8'h00);
    pulse(8'h01);
    req_chk(1, 8'h80, "R6 after rotate clear");
    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule